// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Deferred Batches

The block collects interrupt sources in nine groups of 32 lines and gives each group one level output. A group turns a rising edge on any of its enabled lines into a batch. The batch is written to the group's status register and raises the group output. Software takes the batch, services each source, and writes ones to status to acknowledge it. Any edge that arrives while the group still shows an unacknowledged batch, or while the group is masked, is held back in a hidden pending vector. That vector becomes the next batch once status reaches zero.

Each group also has an enable register, and a write to it acts in one of two ways. A write that adds lines to the group's enable set extends that set, which never shrinks. A write that adds nothing is taken as a mask or unmask command. The bits that differ from the last value written mark the affected lines. The command unmasks if any of those lines are set in the new value, and masks otherwise. Register access is a simple 32-bit bus: one write per cycle, with combinational read data.

Top module: `irq_bank_agg`

## Requirements
- R1: Group n (0..8) has its enable register at byte address n*0x100 and its status register at n*0x100+4. Reads return the addressed value in the same cycle. Any other address reads zero, and writes to it change no state.
- R2: A rising edge on an enabled line is captured. The group must have status zero and mask zero. In the next cycle status equals the set of enabled lines that rose, and the group output is high. Lines that rise together form one batch.
- R3: A line that is not enabled, or that stays high without a new rising edge, changes neither status nor the output.
- R4: A captured edge in a group whose status is nonzero leaves status and the output unchanged, and is added to the hidden pending vector.
- R5: The hidden enable set is the OR of all data written to the enable register. The readable enable register returns the last value written. Writing zero while the set is empty stores zero and enables nothing.
- R6: An enable write that adds no new lines, where the changed bits (last value XOR data) ANDed with the data give zero, sets those changed bits in the mask. While the mask is nonzero, edges go to pending even if status is zero.
- R7: An enable write that adds no new lines, where the changed bits ANDed with the data give a nonzero value, clears the changed bits from the mask.
- R8: A nonzero status write clears each status bit written as one. If status stays nonzero, the output stays high.
- R9: If a status write, other than all ones, leaves status at zero, one of two things happens. With pending nonzero, status takes the pending value, pending is cleared, and the output stays or goes high. With pending zero, the output goes low.
- R10: A status write of all ones clears status but moves no pending value and does not change the output.
- R11: A status write of zero changes nothing. The error output is high for exactly the cycle after that write.
- R12: A status write and a captured edge may hit the same group in the same cycle. The write is applied first, and the edge is then judged against the resulting status.
- R13: Reset clears enable, readable enable, mask, pending, status, the outputs and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 288 | Source lines, group g at bits [g*32 +: 32] |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 9 | Per-group interrupt level |
| zero_clr_err_o | output | 1 | One-cycle flag after a zero status write |

## Verification
All state and every output are registered, with one exception: read data is combinational from the address. A source change or a register write applied before a clock edge therefore shows on irq_o, on zero_clr_err_o and in readback right after that edge, so each result is due one cycle after its stimulus. The bench drives inputs on the falling edge and lets one rising edge pass. It then samples outputs and readback during the low phase, so each check falls in the cycle where its result first appears. The same-cycle case drives a write and a source edge in one low phase, so both land on the same rising edge.

// File: rtl/irq_bank_agg.sv
module irq_bank_agg #(
  parameter int NGRP  = 9,
  parameter int NLINE = 32,
  parameter int AW    = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NGRP*NLINE-1:0]  src_i,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [NLINE-1:0]       bus_wdata,
  output logic [NLINE-1:0]       bus_rdata,
  output logic [NGRP-1:0]        irq_o,
  output logic                   zero_clr_err_o
);
  localparam int GW = AW - 8;
  localparam logic [7:0] OFF_EN = 8'h00;
  localparam logic [7:0] OFF_ST = 8'h04;

  logic [NGRP*NLINE-1:0] src_q;
  logic [NGRP*NLINE-1:0] rise;
  logic [GW-1:0] grp;
  logic [7:0] off;
  logic grp_ok;
  logic [NGRP-1:0][NLINE-1:0] en_view, st_view;

  assign grp    = bus_addr[AW-1:8];
  assign off    = bus_addr[7:0];
  assign grp_ok = 32'(grp) < NGRP;
  assign rise   = src_i & ~src_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_q          <= '0;
      zero_clr_err_o <= 1'b0;
    end else begin
      src_q          <= src_i;
      zero_clr_err_o <= bus_we && grp_ok && off == OFF_ST && bus_wdata == '0;
    end

  always_comb begin
    bus_rdata = '0;
    if (grp_ok && off == OFF_EN) bus_rdata = en_view[grp];
    if (grp_ok && off == OFF_ST) bus_rdata = st_view[grp];
  end

  for (genvar g = 0; g < NGRP; g++) begin : gen_grp
    logic [NLINE-1:0] en_acc, en_rd, msk, pnd, sts;
    logic [NLINE-1:0] en_acc_n, en_rd_n, msk_n, pnd_n, sts_n, sel, chg;
    logic irq, irq_n, hit, en_wr, st_wr;

    assign hit   = bus_we && grp_ok && grp == GW'(g);
    assign en_wr = hit && off == OFF_EN;
    assign st_wr = hit && off == OFF_ST;
    assign chg   = en_rd ^ bus_wdata;
    assign sel   = rise[g*NLINE +: NLINE] & en_acc;

    always_comb begin
      en_acc_n = en_acc;
      en_rd_n  = en_rd;
      msk_n    = msk;
      if (en_wr) begin
        en_rd_n = bus_wdata;
        if (!(bus_wdata == '0 && en_acc == '0)) begin
          if ((en_acc | bus_wdata) != en_acc) en_acc_n = en_acc | bus_wdata;
          else if ((chg & bus_wdata) != '0)   msk_n = msk & ~chg;
          else                                msk_n = msk | chg;
        end
      end
    end

    always_comb begin
      sts_n = sts;
      pnd_n = pnd;
      irq_n = irq;
      if (st_wr && bus_wdata != '0) begin
        sts_n = sts & ~bus_wdata;
        if (bus_wdata != '1 && sts_n == '0) begin
          if (pnd != '0) begin
            sts_n = pnd;
            pnd_n = '0;
            irq_n = 1'b1;
          end else begin
            irq_n = 1'b0;
          end
        end
      end
      if (sel != '0) begin
        if (msk != '0 || sts_n != '0) pnd_n = pnd_n | sel;
        else begin
          sts_n = sel;
          irq_n = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en_acc <= '0;
        en_rd  <= '0;
        msk    <= '0;
        pnd    <= '0;
        sts    <= '0;
        irq    <= 1'b0;
      end else begin
        en_acc <= en_acc_n;
        en_rd  <= en_rd_n;
        msk    <= msk_n;
        pnd    <= pnd_n;
        sts    <= sts_n;
        irq    <= irq_n;
      end

    assign en_view[g] = en_rd;
    assign st_view[g] = sts;
    assign irq_o[g]   = irq;
  end
endmodule

// File: rtl/irq_bank_agg_chk.sv
module irq_bank_agg_chk #(
  parameter int NGRP  = 9,
  parameter int NLINE = 32,
  parameter int AW    = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NGRP*NLINE-1:0] src_i,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [NLINE-1:0]      bus_wdata,
  input logic [NLINE-1:0]      bus_rdata,
  input logic [NGRP-1:0]       irq_o,
  input logic                  zero_clr_err_o
);
  logic [NGRP*NLINE-1:0] seen;
  logic [AW-9:0] grp;
  logic st_addr, st_zero, rose_any;

  assign grp      = bus_addr[AW-1:8];
  assign st_addr  = 32'(grp) < NGRP && bus_addr[7:0] == 8'h04;
  assign st_zero  = bus_we && st_addr && bus_wdata == '0;
  assign rose_any = |(src_i & ~seen);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else        seen <= src_i;

  // R11
  err_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_zero |=> zero_clr_err_o);

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_clr_err_o |-> $past(st_zero));

  // R2
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(irq_o)) != '0 |-> $past(bus_we || rose_any));

  // R8
  irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_o) & ~irq_o) != '0 |-> $past(bus_we));

  // R9
  idle_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && st_addr && !irq_o[grp]) |-> bus_rdata == '0);
endmodule

bind irq_bank_agg irq_bank_agg_chk #(.NGRP(NGRP), .NLINE(NLINE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .zero_clr_err_o(zero_clr_err_o)
);

// File: tb/sim_irq_bank_agg.sv
module sim_irq_bank_agg;
  localparam int NGRP = 9, NLINE = 32, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NGRP*NLINE-1:0] src = '0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NLINE-1:0] bus_wdata = '0;
  logic [NLINE-1:0] bus_rdata;
  logic [NGRP-1:0] irq_o;
  logic zero_clr_err_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_bank_agg #(.NGRP(NGRP), .NLINE(NLINE), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .zero_clr_err_o(zero_clr_err_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [AW-1:0] ea(int g); return AW'(g * 256); endfunction
  function automatic logic [AW-1:0] sa(int g); return AW'(g * 256 + 4); endfunction

  task automatic setsrc(int g, logic [31:0] v);
    src[g*NLINE +: NLINE] = v;
    @(negedge clk);
  endtask

  task automatic st_is(string req, int g, logic [31:0] exp_st, logic exp_irq);
    logic [31:0] v;
    rd(sa(g), v);
    chk(req, v, exp_st);
    chk(req, 32'(irq_o[g]), 32'(exp_irq));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R13 irq", 32'(irq_o), 0);
    chk("R13 err", 32'(zero_clr_err_o), 0);
    rd(ea(0), v); chk("R13 en0", v, 0);
    rd(sa(8), v); chk("R13 st8", v, 0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(ea(3), 32'h0000_00f0);
    rd(ea(3), v); chk("R1 en3", v, 32'hf0);
    rd(sa(3), v); chk("R1 st3", v, 0);
    rd(12'h308, v); chk("R1 hole read", v, 0);
    wr(12'h310, 32'hdead_beef);
    wr(12'h900, 32'h1234_5678);
    rd(ea(3), v); chk("R1 en3 after stray", v, 32'hf0);
    rd(12'h900, v); chk("R1 group9 read", v, 0);
    rd(12'h310, v); chk("R1 stray read", v, 0);
  endtask

  task automatic t_fire;
    wr(ea(0), 32'h5);
    setsrc(0, 32'h10);
    st_is("R3 unenabled", 0, 0, 0);
    setsrc(0, 32'h15);
    st_is("R2 batch", 0, 32'h5, 1);
    chk("R2 others low", 32'(irq_o[8:1]), 0);
    wr(sa(0), 32'h5);
    setsrc(0, 32'h15);
    st_is("R3 held level", 0, 0, 0);
    setsrc(0, 0);
  endtask

  task automatic t_pending;
    wr(ea(1), 32'hff);
    setsrc(1, 32'h1); setsrc(1, 0);
    st_is("R2 g1", 1, 32'h1, 1);
    setsrc(1, 32'h8); setsrc(1, 0);
    st_is("R4 busy", 1, 32'h1, 1);
    wr(sa(1), 32'h1);
    st_is("R9 handoff", 1, 32'h8, 1);
    wr(sa(1), 32'h8);
    st_is("R9 drop", 1, 0, 0);
  endtask

  task automatic t_partial;
    wr(ea(2), 32'hf);
    setsrc(2, 32'h3); setsrc(2, 0);
    wr(sa(2), 32'h1);
    st_is("R8 partial", 2, 32'h2, 1);
    wr(sa(2), 32'h2);
    st_is("R8 final", 2, 0, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(ea(5), 32'h0);
    rd(ea(5), v); chk("R5 zero write", v, 0);
    setsrc(5, 32'h1); setsrc(5, 0);
    st_is("R5 nothing enabled", 5, 0, 0);
    wr(ea(5), 32'h1);
    wr(ea(5), 32'h2);
    rd(ea(5), v); chk("R5 readable last", v, 32'h2);
    setsrc(5, 32'h1); setsrc(5, 0);
    st_is("R5 accumulated", 5, 32'h1, 1);
    wr(sa(5), 32'h1);
    wr(ea(4), 32'h3);
    wr(ea(4), 32'h1);
    setsrc(4, 32'h1); setsrc(4, 0);
    st_is("R6 masked", 4, 0, 0);
    wr(ea(4), 32'h3);
    setsrc(4, 32'h2); setsrc(4, 0);
    st_is("R7 unmasked", 4, 32'h2, 1);
    wr(sa(4), 32'h2);
    st_is("R6 held pending", 4, 32'h1, 1);
    wr(sa(4), 32'h1);
    st_is("R9 g4 drop", 4, 0, 0);
  endtask

  task automatic t_init;
    wr(ea(6), 32'h3);
    setsrc(6, 32'h1); setsrc(6, 0);
    setsrc(6, 32'h2); setsrc(6, 0);
    wr(sa(6), 32'hffff_ffff);
    st_is("R10 init", 6, 0, 1);
    wr(sa(6), 32'h1);
    st_is("R9 after init", 6, 32'h2, 1);
    wr(sa(6), 32'h2);
    st_is("R9 g6 drop", 6, 0, 0);
  endtask

  task automatic t_zero;
    wr(ea(7), 32'h1);
    setsrc(7, 32'h1); setsrc(7, 0);
    bus_we = 1'b1; bus_addr = sa(7); bus_wdata = '0;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R11 err pulse", 32'(zero_clr_err_o), 1);
    st_is("R11 no change", 7, 32'h1, 1);
    @(negedge clk);
    chk("R11 err ends", 32'(zero_clr_err_o), 0);
  endtask

  task automatic t_same;
    wr(ea(8), 32'h3);
    setsrc(8, 32'h1); setsrc(8, 0);
    bus_we = 1'b1; bus_addr = sa(8); bus_wdata = 32'h1;
    src[8*NLINE +: NLINE] = 32'h2;
    @(negedge clk);
    bus_we = 1'b0;
    st_is("R12 write first", 8, 32'h2, 1);
    setsrc(8, 0);
  endtask

  task automatic t_rerst;
    logic [31:0] v;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R13 irq after", 32'(irq_o), 0);
    rd(sa(8), v); chk("R13 st8 after", v, 0);
    rd(ea(3), v); chk("R13 en3 after", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_decode;
    t_fire;
    t_pending;
    t_partial;
    t_mask;
    t_init;
    t_zero;
    t_same;
    t_rerst;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule